// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Controller

This block is the register front end of a boot-security unit. Software reaches it through a simple 32-bit register bus with a 4 KiB decoded window. A fuse-style memory of 4096 dwords sits behind it on a separate port with a one-cycle read latency. Software starts work on that memory by writing a full 32-bit key word to a command location. The block then runs a short access sequence and shows its progress in two idle bits of a read-only status word.

Three operations exist. A fetch copies memory contents into two capture registers. In the lower half of the array it copies a pair of dwords, and in the upper half it copies a single dword. A burn merges the first capture register into one addressed dword, and bits can only go from 0 to 1. A mode command touches nothing in the array and only checks that its address is one of the accepted mode selectors. Unknown keys, out-of-range addresses and illegal register accesses each raise a one-cycle error pulse. A one-cycle done pulse marks the cycle in which the idle bits come back.

The sequencer has eight named states. SQ_IDLE waits for a command. SQ_RD_LO and SQ_RD_HI issue array reads, and SQ_CAP_LO and SQ_CAP_HI load the capture registers. SQ_PG_FETCH reads the dword that is about to be burned, and SQ_PG_MERGE writes back the ORed value. SQ_FINISH closes every command. Its transitions are listed below.
- idle→rd_lo: fetch, address in range
- idle→pg_fetch: burn, address in range
- idle→finish: any other accepted key write
- rd_lo→cap_lo
- cap_lo→rd_hi: data region
- cap_lo→finish: config region
- rd_hi→cap_hi
- cap_hi→finish
- pg_fetch→pg_merge
- pg_merge→finish
- finish→idle

Top module: `otp_cmd_ctrl`

## Requirements
- R1: Bus byte offsets 0x000 (guard word), 0x010 (array address), 0x020 (capture A) and 0x024 (capture B) are read/write registers. A read answers with bus_rvalid and bus_rdata one cycle after the request. Unmapped offsets up to 0x040 read 0 and ignore writes without an error.
- R2: A synchronous reset (rst_n low) clears every register. Status then reads 0x00000006. Offset 0x040 reads strap_in AND 0x00003C00, sampled while reset is held: bits 13:12 are the signature mode and bits 11:10 are the digest mode.
- R3: Offset 0x004 accepts only three key words: 0x23B1E361 (fetch), 0x23B1E362 (mode) and 0x23B1E364 (burn). It reads as 0. Any other word pulses err_o and changes no capture register and no array dword.
- R4: Status bit 1 (array idle) and bit 2 (controller idle) read 0 from the cycle after a command is accepted until the command ends. They reappear together with a one-cycle done_o. A command lasts 5 cycles for a pair fetch, 3 for a single fetch, 3 for a burn and 1 for any rejected or mode command.
- R5: A fetch at dword address N below 0x800 loads capture A with array[N] and capture B with array[N+1].
- R6: A fetch at an address from 0x800 to 0xFFF loads only capture A. A fetch at 0x1000 or above pulses err_o and leaves both captures unchanged.
- R7: A burn at address N below 0x1000 sets array[N] to array[N] OR the capture A value held when the command was accepted. At 0x1000 or above it pulses err_o and writes nothing.
- R8: A mode command with address 0, 0x1000, 0x3000 or 0x5000 completes without an array access or an error. Any other address pulses err_o.
- R9: Writes to status (0x014) or strap (0x040) are discarded and pulse err_o. Reads above 0x040 return 0 and writes there are dropped, both with an err_o pulse.
- R10: A key write while a command is running is ignored, without an error and without starting anything.
- R11: When a bus write to a capture register lands on the same edge on which the sequencer loads that register, the sequencer's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 32 | Signing settings, sampled during reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| otp_rd_en | output | 1 | Array read strobe |
| otp_wr_en | output | 1 | Array write strobe |
| otp_addr | output | 12 | Array dword address |
| otp_wdata | output | 32 | Array write data |
| otp_rdata | input | 32 | Array read data, one cycle after otp_rd_en |
| done_o | output | 1 | One-cycle pulse when idle bits return |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bus and the sequencer can both write capture A, or both write capture B, on the same clock edge. The sequencer writes capture A two edges after a pair fetch is accepted and capture B four edges after. The bench issues bus writes to each capture register on exactly those edges, with filler reads in between to set the spacing. A behavioural per-cycle model, in which the sequencer load takes effect after the bus write, predicts the read-back. Every bus read is compared against that model, so the stray bus data must never show through.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;

    localparam int unsigned WORD_W = 32;

    // command key words
    localparam logic [31:0] KEY_FETCH = 32'h23B1E361;
    localparam logic [31:0] KEY_MODE  = 32'h23B1E362;
    localparam logic [31:0] KEY_BURN  = 32'h23B1E364;

    // accepted mode selector addresses
    localparam logic [31:0] MODE_SEL_A = 32'h0000_1000;
    localparam logic [31:0] MODE_SEL_B = 32'h0000_3000;
    localparam logic [31:0] MODE_SEL_C = 32'h0000_5000;

    // dword indices inside the register window
    localparam int unsigned IDX_GUARD  = 0;
    localparam int unsigned IDX_KEY    = 1;
    localparam int unsigned IDX_ADDR   = 4;
    localparam int unsigned IDX_STATUS = 5;
    localparam int unsigned IDX_CAPA   = 8;
    localparam int unsigned IDX_CAPB   = 9;
    localparam int unsigned IDX_STRAP  = 16;

    localparam logic [31:0] STRAP_MASK = 32'h0000_3C00;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RD_LO,
        SQ_CAP_LO,
        SQ_RD_HI,
        SQ_CAP_HI,
        SQ_PG_FETCH,
        SQ_PG_MERGE,
        SQ_FINISH
    } seq_state_e;

endpackage

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
    import otp_ctrl_pkg::*;
#(
    parameter int unsigned OTP_AW      = 12,
    parameter int unsigned DATA_WORDS  = 2048,
    parameter int unsigned TOTAL_WORDS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] capa_cur,
    input  logic [WORD_W-1:0] otp_rdata,
    output logic              busy,
    output logic              capa_ld,
    output logic              capb_ld,
    output logic [WORD_W-1:0] cap_val,
    output logic              otp_rd_en,
    output logic              otp_wr_en,
    output logic [OTP_AW-1:0] otp_addr,
    output logic [WORD_W-1:0] otp_wdata,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [WORD_W-1:0] DATA_LIM  = WORD_W'(DATA_WORDS);
    localparam logic [WORD_W-1:0] TOTAL_LIM = WORD_W'(TOTAL_WORDS);

    seq_state_e        state_q, state_d;
    logic [OTP_AW-1:0] op_addr_q;
    logic [WORD_W-1:0] op_data_q;
    logic              op_pair_q;

    logic in_range, mode_ok, accept_fetch, accept_burn, accept_mode, reject;

    assign in_range     = cmd_addr < TOTAL_LIM;
    assign mode_ok      = (cmd_addr == '0) || (cmd_addr == MODE_SEL_A) ||
                          (cmd_addr == MODE_SEL_B) || (cmd_addr == MODE_SEL_C);
    assign accept_fetch = (cmd_word == KEY_FETCH) && in_range;
    assign accept_burn  = (cmd_word == KEY_BURN) && in_range;
    assign accept_mode  = (cmd_word == KEY_MODE) && mode_ok;
    assign reject       = fire && (state_q == SQ_IDLE) &&
                          !(accept_fetch || accept_burn || accept_mode);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // operand capture at command acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr_q <= '0;
            op_data_q <= '0;
            op_pair_q <= 1'b0;
        end else if (fire && state_q == SQ_IDLE) begin
            op_addr_q <= cmd_addr[OTP_AW-1:0];
            op_data_q <= capa_cur;
            op_pair_q <= cmd_addr < DATA_LIM;
        end
    end

    // completion and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= state_q == SQ_FINISH;
            err_o  <= reject;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (fire) begin
                    if (accept_fetch)     state_d = SQ_RD_LO;
                    else if (accept_burn) state_d = SQ_PG_FETCH;
                    else                  state_d = SQ_FINISH;
                end
            end
            SQ_RD_LO:    state_d = SQ_CAP_LO;
            SQ_CAP_LO:   state_d = op_pair_q ? SQ_RD_HI : SQ_FINISH;
            SQ_RD_HI:    state_d = SQ_CAP_HI;
            SQ_CAP_HI:   state_d = SQ_FINISH;
            SQ_PG_FETCH: state_d = SQ_PG_MERGE;
            SQ_PG_MERGE: state_d = SQ_FINISH;
            SQ_FINISH:   state_d = SQ_IDLE;
            default:     state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = state_q != SQ_IDLE;
        capa_ld   = 1'b0;
        capb_ld   = 1'b0;
        cap_val   = otp_rdata;
        otp_rd_en = 1'b0;
        otp_wr_en = 1'b0;
        otp_addr  = op_addr_q;
        otp_wdata = otp_rdata | op_data_q;
        unique case (state_q)
            SQ_RD_LO:    otp_rd_en = 1'b1;
            SQ_CAP_LO:   capa_ld   = 1'b1;
            SQ_RD_HI: begin
                otp_rd_en = 1'b1;
                otp_addr  = op_addr_q + OTP_AW'(1);
            end
            SQ_CAP_HI:   capb_ld   = 1'b1;
            SQ_PG_FETCH: otp_rd_en = 1'b1;
            SQ_PG_MERGE: otp_wr_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/otp_regs.sv
module otp_regs
    import otp_ctrl_pkg::*;
#(
    parameter int unsigned BUS_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] strap_in,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              busy,
    input  logic              capa_ld,
    input  logic              capb_ld,
    input  logic [WORD_W-1:0] cap_val,
    output logic              fire,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] capa_q,
    output logic              acc_err
);

    localparam int unsigned IDX_W = BUS_AW - 2;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] guard_q, capb_q, strap_q, status_w, rd_mux;
    logic              beyond, wr_ro;

    assign idx      = bus_addr[BUS_AW-1:2];
    assign beyond   = idx > IDX_W'(IDX_STRAP);
    assign wr_ro    = bus_we && (idx == IDX_W'(IDX_STATUS) || idx == IDX_W'(IDX_STRAP));
    assign fire     = bus_req && bus_we && idx == IDX_W'(IDX_KEY) && !busy;
    assign status_w = {{(WORD_W-3){1'b0}}, !busy, !busy, 1'b0};

    always_comb begin
        rd_mux = '0;
        if (idx == IDX_W'(IDX_GUARD))       rd_mux = guard_q;
        else if (idx == IDX_W'(IDX_ADDR))   rd_mux = addr_q;
        else if (idx == IDX_W'(IDX_STATUS)) rd_mux = status_w;
        else if (idx == IDX_W'(IDX_CAPA))   rd_mux = capa_q;
        else if (idx == IDX_W'(IDX_CAPB))   rd_mux = capb_q;
        else if (idx == IDX_W'(IDX_STRAP))  rd_mux = strap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= '0;
            addr_q  <= '0;
            capa_q  <= '0;
            capb_q  <= '0;
            strap_q <= strap_in & STRAP_MASK;
        end else begin
            if (bus_req && bus_we) begin
                if (idx == IDX_W'(IDX_GUARD)) guard_q <= bus_wdata;
                if (idx == IDX_W'(IDX_ADDR))  addr_q  <= bus_wdata;
                if (idx == IDX_W'(IDX_CAPA))  capa_q  <= bus_wdata;
                if (idx == IDX_W'(IDX_CAPB))  capb_q  <= bus_wdata;
            end
            // sequencer loads take precedence over bus writes
            if (capa_ld) capa_q <= cap_val;
            if (capb_ld) capb_q <= cap_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            acc_err    <= 1'b0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            acc_err    <= bus_req && (beyond || wr_ro);
            if (bus_req && !bus_we) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
    import otp_ctrl_pkg::*;
#(
    parameter int unsigned BUS_AW      = 12,
    parameter int unsigned OTP_AW      = 12,
    parameter int unsigned DATA_WORDS  = 2048,
    parameter int unsigned TOTAL_WORDS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       strap_in,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              otp_rd_en,
    output logic              otp_wr_en,
    output logic [OTP_AW-1:0] otp_addr,
    output logic [31:0]       otp_wdata,
    input  logic [31:0]       otp_rdata,
    output logic              done_o,
    output logic              err_o
);

    logic              busy, fire, capa_ld, capb_ld, acc_err, seq_err;
    logic [WORD_W-1:0] cap_val, addr_q, capa_q;

    otp_regs #(.BUS_AW(BUS_AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_in   (strap_in),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .busy       (busy),
        .capa_ld    (capa_ld),
        .capb_ld    (capb_ld),
        .cap_val    (cap_val),
        .fire       (fire),
        .addr_q     (addr_q),
        .capa_q     (capa_q),
        .acc_err    (acc_err)
    );

    otp_seq_fsm #(
        .OTP_AW      (OTP_AW),
        .DATA_WORDS  (DATA_WORDS),
        .TOTAL_WORDS (TOTAL_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .cmd_word  (bus_wdata),
        .cmd_addr  (addr_q),
        .capa_cur  (capa_q),
        .otp_rdata (otp_rdata),
        .busy      (busy),
        .capa_ld   (capa_ld),
        .capb_ld   (capb_ld),
        .cap_val   (cap_val),
        .otp_rd_en (otp_rd_en),
        .otp_wr_en (otp_wr_en),
        .otp_addr  (otp_addr),
        .otp_wdata (otp_wdata),
        .done_o    (done_o),
        .err_o     (seq_err)
    );

    assign err_o = seq_err | acc_err;

endmodule

// File: rtl/otp_cmd_ctrl_chk.sv
module otp_cmd_ctrl_chk #(
    parameter int unsigned BUS_AW = 12,
    parameter int unsigned OTP_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              otp_rd_en,
    input logic              otp_wr_en,
    input logic [OTP_AW-1:0] otp_addr,
    input logic              done_o,
    input logic              err_o,
    input logic              busy
);

    // R1
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R4
    key_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[BUS_AW-1:2] == 1 && !busy) |=> busy);

    // R4
    done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy && $past(busy)));

    // R7
    merge_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_wr_en |-> ($past(otp_rd_en) && otp_addr == $past(otp_addr)));

    // R7
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(otp_rd_en && otp_wr_en));

    // R8
    array_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_rd_en || otp_wr_en) |-> busy);

    // R9
    status_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[BUS_AW-1:2] == 5) |=> err_o);

endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk #(.BUS_AW(BUS_AW), .OTP_AW(OTP_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .otp_rd_en  (otp_rd_en),
    .otp_wr_en  (otp_wr_en),
    .otp_addr   (otp_addr),
    .done_o     (done_o),
    .err_o      (err_o),
    .busy       (busy)
);

// File: tb/sim_otp_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_otp_cmd_ctrl;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] strap_in = 32'hFFFF_FFFF;
    logic        bus_req = 0, bus_we = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        otp_rd_en, otp_wr_en;
    logic [11:0] otp_addr;
    logic [31:0] otp_wdata;
    logic [31:0] otp_rdata = 0;
    logic        done_o, err_o;

    always #2.5 clk = ~clk;

    otp_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .otp_rd_en(otp_rd_en), .otp_wr_en(otp_wr_en), .otp_addr(otp_addr),
        .otp_wdata(otp_wdata), .otp_rdata(otp_rdata),
        .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // array seen by the design, and the model's own array
    logic [31:0] env_mem [int];
    logic [31:0] mod_mem [int];

    function automatic logic [31:0] env_get(int a);
        return env_mem.exists(a) ? env_mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] mod_get(int a);
        return mod_mem.exists(a) ? mod_mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (otp_rd_en) otp_rdata <= env_get(int'(otp_addr));
        if (otp_wr_en) env_mem[int'(otp_addr)] = otp_wdata;
    end

    // ---------------- behavioural reference model ----------------
    int          cyc = 0, t0 = 0, len = 0;
    bit          m_busy = 0, m_err = 0, m_done = 0, m_rv = 0;
    logic [31:0] m_rd = 0, m_guard = 0, m_addr = 0, m_capa = 0, m_capb = 0, m_strap = 0;
    bit          p_a = 0, p_b = 0, p_m = 0;
    logic [31:0] v_a = 0, v_b = 0, v_m = 0;
    int          a_m = 0;
    string       err_tag = "R9", rd_tag = "R1";

    function automatic logic [31:0] model_read(int idx);
        case (idx)
            0:  return m_guard;
            4:  return m_addr;
            5:  return m_busy ? 32'h0 : 32'h6;
            8:  return m_capa;
            9:  return m_capb;
            16: return m_strap;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            1: return "R3";
            5: return "R4";
            8, 9: return "R5";
            16: return "R2";
            default: return (idx > 16) ? "R9" : "R1";
        endcase
    endfunction

    task automatic model_start(input logic [31:0] key, output bit e);
        e = 0;
        t0 = cyc; m_busy = 1; p_a = 0; p_b = 0; p_m = 0; len = 1;
        if (key == 32'h23B1E361) begin
            if (m_addr < 32'h1000) begin
                p_a = 1; v_a = mod_get(int'(m_addr)); len = 3;
                if (m_addr < 32'h800) begin
                    p_b = 1; v_b = mod_get(int'(m_addr) + 1); len = 5;
                end
            end else begin e = 1; err_tag = "R6"; end
        end else if (key == 32'h23B1E364) begin
            if (m_addr < 32'h1000) begin
                p_m = 1; a_m = int'(m_addr); v_m = m_capa; len = 3;
            end else begin e = 1; err_tag = "R7"; end
        end else if (key == 32'h23B1E362) begin
            if (!(m_addr == 0 || m_addr == 32'h1000 || m_addr == 32'h3000 || m_addr == 32'h5000)) begin
                e = 1; err_tag = "R8";
            end
        end else begin e = 1; err_tag = "R3"; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_done = 0; m_rv = 0; m_rd = 0;
            m_guard = 0; m_addr = 0; m_capa = 0; m_capb = 0;
            m_strap = strap_in & 32'h0000_3C00;
            p_a = 0; p_b = 0; p_m = 0;
        end else begin
            bit was_busy, ne, nd, nr, se;
            int idx;
            was_busy = m_busy; ne = 0; nd = 0; nr = 0;
            idx = int'(bus_addr[11:2]);
            if (bus_req && !bus_we) begin
                nr = 1; m_rd = model_read(idx); rd_tag = tag_of(idx);
                if (idx > 16) begin ne = 1; err_tag = "R9"; end
            end else if (bus_req && bus_we) begin
                case (idx)
                    0: m_guard = bus_wdata;
                    4: m_addr = bus_wdata;
                    8: m_capa = bus_wdata;
                    9: m_capb = bus_wdata;
                    1: if (!was_busy) begin model_start(bus_wdata, se); ne = se; end // R10: else ignored
                    5, 16: begin ne = 1; err_tag = "R9"; end
                    default: if (idx > 16) begin ne = 1; err_tag = "R9"; end
                endcase
            end
            if (was_busy) begin
                if (cyc == t0 + 2 && p_a) m_capa = v_a;            // R11: load after bus write
                if (cyc == t0 + 2 && p_m) mod_mem[a_m] = mod_get(a_m) | v_m;
                if (cyc == t0 + 4 && p_b) m_capb = v_b;
                if (cyc == t0 + len) begin m_busy = 0; nd = 1; end
            end
            m_err = ne; m_done = nd; m_rv = nr;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(err_o === m_err, err_tag, {31'b0, err_o}, {31'b0, m_err});
            chk(done_o === m_done, "R4", {31'b0, done_o}, {31'b0, m_done});
            chk(bus_rvalid === m_rv, "R1", {31'b0, bus_rvalid}, {31'b0, m_rv});
            if (m_rv) chk(bus_rdata === m_rd, rd_tag, bus_rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
    endtask
    task automatic rd(input logic [11:0] a);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
    endtask
    task automatic settle();
        bus_req = 0; bus_we = 0;
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic read_all();
        rd(12'h000); rd(12'h004); rd(12'h010); rd(12'h014);
        rd(12'h020); rd(12'h024); rd(12'h040); rd(12'h008);
        settle();
    endtask

    localparam logic [31:0] K_FETCH = 32'h23B1E361;
    localparam logic [31:0] K_MODE  = 32'h23B1E362;
    localparam logic [31:0] K_BURN  = 32'h23B1E364;

    initial begin
        env_mem[5] = 32'hA5A5_0001;      mod_mem[5] = 32'hA5A5_0001;
        env_mem[6] = 32'h1234_5678;      mod_mem[6] = 32'h1234_5678;
        env_mem[7] = 32'h0000_7777;      mod_mem[7] = 32'h0000_7777;
        env_mem[32'h7FF] = 32'hDEAD_0001; mod_mem[32'h7FF] = 32'hDEAD_0001;
        env_mem[32'h800] = 32'hBEEF_0002; mod_mem[32'h800] = 32'hBEEF_0002;
        env_mem[32'h801] = 32'hCAFE_0003; mod_mem[32'h801] = 32'hCAFE_0003;
        env_mem[32'h100] = 32'h0000_00F0; mod_mem[32'h100] = 32'h0000_00F0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: reset values, strap field
        read_all();

        // R1: guard register and holes
        wr(12'h000, 32'h0BAD_F00D); wr(12'h008, 32'hFFFF_FFFF); read_all();

        // R5 + R4: pair fetch, status during the command
        wr(12'h010, 32'h5); wr(12'h004, K_FETCH); rd(12'h014); rd(12'h004);
        settle(); read_all();

        // R5: pair straddling the region boundary
        wr(12'h010, 32'h7FF); wr(12'h004, K_FETCH); settle(); read_all();

        // R6: single config fetch, then out-of-range fetch
        wr(12'h024, 32'h1111_2222);
        wr(12'h010, 32'h800); wr(12'h004, K_FETCH); settle(); read_all();
        wr(12'h010, 32'h1000); wr(12'h004, K_FETCH); settle(); read_all();

        // R7: burn merges capture A, only sets bits
        wr(12'h020, 32'h0F00_000F); wr(12'h010, 32'h100); wr(12'h004, K_BURN);
        wr(12'h020, 32'h7000_0000);   // change after accept must not matter
        settle();
        chk(env_get(32'h100) === 32'h0F00_00FF, "R7", env_get(32'h100), 32'h0F00_00FF);
        wr(12'h020, 32'h0000_0000); wr(12'h004, K_BURN); settle();
        chk(env_get(32'h100) === 32'h0F00_00FF, "R7", env_get(32'h100), 32'h0F00_00FF);
        wr(12'h020, 32'hFFFF_FFFF); wr(12'h010, 32'h1000); wr(12'h004, K_BURN); settle();
        chk(env_get(32'h1000) === 32'h0, "R7", env_get(32'h1000), 32'h0);

        // R8: mode selectors
        wr(12'h010, 32'h0);    wr(12'h004, K_MODE); settle();
        wr(12'h010, 32'h3000); wr(12'h004, K_MODE); settle();
        wr(12'h010, 32'h5000); wr(12'h004, K_MODE); settle();
        wr(12'h010, 32'h0123); wr(12'h004, K_MODE); settle();
        chk(env_get(32'h123) === 32'h0, "R8", env_get(32'h123), 32'h0);

        // R3: unknown key
        wr(12'h010, 32'h6); wr(12'h020, 32'hAAAA_0000);
        wr(12'h004, 32'h23B1E363); settle(); read_all();
        chk(env_get(6) === 32'h1234_5678, "R3", env_get(6), 32'h1234_5678);

        // R10: key write while busy is ignored
        wr(12'h010, 32'h5); wr(12'h020, 32'h0000_F000);
        wr(12'h004, K_FETCH); wr(12'h004, K_BURN); settle();
        chk(env_get(5) === 32'hA5A5_0001, "R10", env_get(5), 32'hA5A5_0001);
        read_all();

        // R11: bus writes colliding with sequencer capture loads
        wr(12'h010, 32'h6); wr(12'h004, K_FETCH); rd(12'h000);
        wr(12'h020, 32'h5555_5555); rd(12'h000); wr(12'h024, 32'h6666_6666);
        settle(); read_all();

        // R9: read-only and out-of-window accesses
        wr(12'h014, 32'hFFFF_FFFF); wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h080, 32'h1234_0000); rd(12'h080); rd(12'hFFC);
        settle(); read_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule